// File: doc/BRIEF.md
# Serial ADC Command and Readout Controller

This block is the digital side of a multi-channel successive-approximation converter on a three-wire serial bus. It has a chip select, a serial clock, a data input and a data output that can be released. A host pulls chip select low. It may send any number of zero bits, then a start bit, then a seven-bit control word. That word picks the input channel or differential pair, unipolar or signed output, the bit order of the result, and whether the converter stays powered.

After the control word, the block raises a sample strobe for a fixed number of serial-clock falling edges. It then drives a null bit and runs a 12-step successive approximation. Each step places a trial code on the DAC bus and reads back an external comparator. Each decided bit leaves the data output on the same falling edge. In LSB-first mode the stored result is then replayed from bit 0. Zeros follow the data. Raising chip select at any point ends the transaction and releases the output, so several converters can share one bus. The serial pins are oversampled by the system clock through two-flop synchronisers.

Top module: `adc_serial_ctrl`

## Requirements
- R1: After reset, `dout_oe` and `sample` are low, `shdn_n` is high and `bipolar` is low.
- R2: Input bits are taken on serial-clock rising edges. Zeros before the first one are ignored, and that first one is the start bit. The next seven bits are, in order: single-ended (1) / differential (0), odd/sign, select bit 1, select bit 0, unipolar (1) / bipolar (0), MSB-first (1) / LSB-first (0), and run (1) / shutdown (0). No sample strobe or output drive occurs before the word is complete.
- R3: Single-ended: `pos_ch` = {sel1, sel0, odd} and `neg_com` = 1. Differential: `pos_ch` = {sel1, sel0, odd}, `neg_ch` = {sel1, sel0, ~odd} and `neg_com` = 0.
- R4: With run = 1, `sample` rises when the word completes. It stays high until the SMP_FALLS-th falling edge that follows, with a default of 2.
- R5: `dout_oe` stays low until that same falling edge. On that edge it goes high with a zero null bit, and `sample` and `dout_oe` are never high together.
- R6: Unipolar: the result is the largest 12-bit code that the comparator accepts. Comparator = 1 keeps a trial bit. The bits leave MSB first on the 12 falling edges after the null bit.
- R7: Bipolar: the output code is the converted code with its MSB inverted (two's complement), and `bipolar` is high.
- R8: MSB-first: after bit 0, every further falling edge drives zero until chip select rises.
- R9: LSB-first: after the MSB-first pass, the same result is driven again from bit 0 to bit 11, then zeros.
- R10: When chip select goes high, `dout_oe` and `sample` are low on the next cycle and the receiver is cleared. The next transaction hunts for a fresh start bit.
- R11: A word with run = 0 drives `shdn_n` low, with no sample and no output drive. A later word with run = 1 restores `shdn_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| cmp | input | 1 | Comparator: 1 when input is at or above the DAC level |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for the data pin |
| sample | output | 1 | Sample-and-hold track strobe |
| dac_code | output | RES | Trial code for the capacitor DAC |
| pos_ch | output | 3 | Positive mux channel |
| neg_ch | output | 3 | Negative mux channel in differential mode |
| neg_com | output | 1 | Negative input taken from common pin |
| bipolar | output | 1 | Signed conversion selected |
| shdn_n | output | 1 | Low while power shutdown is requested |

## Verification
Embedded properties watch, on every cycle, that chip select high silences the output and the strobe. They also check that strobe and drive never overlap, that the first driven bit is the zero null bit, that a shutdown keeps everything quiet, that each approximation step stores the comparator value it saw, and that control strobes follow only a serial rising edge. Only bench scenarios can show the field order and the channel decoding. The same holds for the exact bit sequence in each order, the sign inversion in bipolar mode and the realignment after an aborted word. The bench checks these with a behavioural comparator fed from the DAC bus.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

  typedef struct packed {
    logic       sgl;
    logic       odd;
    logic [1:0] sel;
    logic       uni;
    logic       msbf;
    logic       pwr;
  } ctl_word_t;

  localparam int CTL_W = $bits(ctl_word_t);

  typedef enum logic [2:0] {
    ST_RX,
    ST_SMP,
    ST_CONV,
    ST_LSB,
    ST_TAIL,
    ST_HOLD
  } seq_st_t;

endpackage

// File: rtl/sync_bus.sv
module sync_bus #(
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {2{RST_VAL[i]}};
      else        pipe <= {pipe[0], d[i]};
    end
    assign q[i] = pipe[1];
  end

endmodule

// File: rtl/cfg_rx.sv
module cfg_rx
  import adc_ser_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      rise,
  input  logic      din,
  output logic      stb,
  output ctl_word_t word
);

  localparam int               CW   = $clog2(CTL_W);
  localparam logic [CW-1:0]    LAST = CW'(CTL_W - 1);

  logic             armed_q, armed_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [CTL_W-1:0] sh_q, sh_n;
  logic             stb_q, stb_n;

  always_comb begin
    armed_n = armed_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    stb_n   = 1'b0;
    if (clr) begin
      armed_n = 1'b0;
      cnt_n   = '0;
    end else if (rise) begin
      if (!armed_q) begin
        armed_n = din;
        cnt_n   = '0;
      end else begin
        sh_n = {sh_q[CTL_W-2:0], din};
        if (cnt_q == LAST) begin
          stb_n   = 1'b1;
          armed_n = 1'b0;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      stb_q   <= 1'b0;
    end else begin
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      stb_q   <= stb_n;
    end
  end

  assign stb  = stb_q;
  assign word = ctl_word_t'(sh_q);

  // R2
  ctl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> ($past(rise) && !$past(clr)));

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           abort,
  input  logic           start,
  input  logic           step_en,
  input  logic           cmp,
  output logic           at_msb,
  output logic           at_lsb,
  output logic [RES-1:0] code,
  output logic [RES-1:0] dac
);

  localparam int SW = $clog2(RES);
  localparam logic [SW-1:0] TOP = SW'(RES - 1);

  logic           busy_q, busy_n;
  logic [SW-1:0]  step_q, step_n;
  logic [RES-1:0] res_q, res_n;

  always_comb begin
    busy_n = busy_q;
    step_n = step_q;
    res_n  = res_q;
    if (abort) begin
      busy_n = 1'b0;
    end else if (start) begin
      busy_n = 1'b1;
      res_n  = '0;
      step_n = TOP;
    end else if (step_en && busy_q) begin
      res_n[step_q] = cmp;
      if (step_q == '0) busy_n = 1'b0;
      else              step_n = step_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      res_q  <= '0;
    end else begin
      busy_q <= busy_n;
      step_q <= step_n;
      res_q  <= res_n;
    end
  end

  assign at_msb = busy_q && (step_q == TOP);
  assign at_lsb = busy_q && (step_q == '0);
  assign code   = res_q;
  assign dac    = busy_q ? (res_q | (RES'(1) << step_q)) : res_q;

  // R6
  sar_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && step_en && !abort && !start) |=> (res_q[$past(step_q)] == $past(cmp)));

endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_ser_pkg::*;
#(
  parameter int RES       = 12,
  parameter int SMP_FALLS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic           din,
  input  logic           cmp,
  output logic           dout,
  output logic           dout_oe,
  output logic           sample,
  output logic [RES-1:0] dac_code,
  output logic [2:0]     pos_ch,
  output logic [2:0]     neg_ch,
  output logic           neg_com,
  output logic           bipolar,
  output logic           shdn_n
);

  localparam int CNT_MAX = (RES > SMP_FALLS) ? RES : SMP_FALLS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam ctl_word_t CFG_RST = '{sgl: 1'b1, odd: 1'b0, sel: 2'b00,
                                    uni: 1'b1, msbf: 1'b1, pwr: 1'b1};

  // pin synchronisers: [2] cs_n, [1] sclk, [0] din
  logic [2:0] pin_q;
  sync_bus #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, din}), .q(pin_q));

  logic cs_hi, sclk_s, din_s, sclk_d;
  assign cs_hi  = pin_q[2];
  assign sclk_s = pin_q[1];
  assign din_s  = pin_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  logic s_rise, s_fall;
  assign s_rise = sclk_s & ~sclk_d;
  assign s_fall = ~sclk_s & sclk_d;

  seq_st_t    st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  ctl_word_t  cfg_q, cfg_n;
  logic       shdn_q, shdn_n_nx;
  logic       dout_q, dout_n;
  logic       oe_q, oe_n;
  logic       smp_q, smp_n;

  logic       rx_clr, rx_stb;
  ctl_word_t  rx_word;
  assign rx_clr = cs_hi || (st_q != ST_RX);

  cfg_rx u_rx (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .rise(s_rise), .din(din_s),
    .stb(rx_stb), .word(rx_word));

  logic           sar_start, sar_step, at_msb, at_lsb;
  logic [RES-1:0] sar_code, out_code;
  assign sar_step = (st_q == ST_CONV) && s_fall && !cs_hi;

  sar_engine #(.RES(RES)) u_sar (
    .clk(clk), .rst_n(rst_n), .abort(cs_hi), .start(sar_start),
    .step_en(sar_step), .cmp(cmp), .at_msb(at_msb), .at_lsb(at_lsb),
    .code(sar_code), .dac(dac_code));

  assign out_code = sar_code ^ {~cfg_q.uni, {(RES-1){1'b0}}};

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    cfg_n     = cfg_q;
    shdn_n_nx = shdn_q;
    dout_n    = dout_q;
    oe_n      = oe_q;
    smp_n     = smp_q;
    sar_start = 1'b0;
    if (cs_hi) begin
      st_n   = ST_RX;
      oe_n   = 1'b0;
      dout_n = 1'b0;
      smp_n  = 1'b0;
      cnt_n  = '0;
    end else begin
      unique case (st_q)
        ST_RX: if (rx_stb) begin
          cfg_n     = rx_word;
          shdn_n_nx = rx_word.pwr;
          cnt_n     = '0;
          if (rx_word.pwr) begin
            st_n  = ST_SMP;
            smp_n = 1'b1;
          end else begin
            st_n = ST_HOLD;
          end
        end
        ST_SMP: if (s_fall) begin
          if (cnt_q == CNT_W'(SMP_FALLS - 1)) begin
            smp_n     = 1'b0;
            oe_n      = 1'b1;
            dout_n    = 1'b0;
            sar_start = 1'b1;
            st_n      = ST_CONV;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_CONV: if (s_fall) begin
          dout_n = cmp ^ (at_msb & ~cfg_q.uni);
          if (at_lsb) begin
            cnt_n = '0;
            st_n  = cfg_q.msbf ? ST_TAIL : ST_LSB;
          end
        end
        ST_LSB: if (s_fall) begin
          dout_n = out_code[cnt_q];
          if (cnt_q == CNT_W'(RES - 1)) st_n = ST_TAIL;
          else                          cnt_n = cnt_q + 1'b1;
        end
        ST_TAIL: if (s_fall) dout_n = 1'b0;
        ST_HOLD: ;
        default: st_n = ST_RX;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RX;
      cnt_q  <= '0;
      cfg_q  <= CFG_RST;
      shdn_q <= 1'b1;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
      smp_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      cfg_q  <= cfg_n;
      shdn_q <= shdn_n_nx;
      dout_q <= dout_n;
      oe_q   <= oe_n;
      smp_q  <= smp_n;
    end
  end

  always_comb begin
    pos_ch = {cfg_q.sel, cfg_q.odd};
    if (cfg_q.sgl) begin
      neg_ch  = '0;
      neg_com = 1'b1;
    end else begin
      neg_ch  = {cfg_q.sel, ~cfg_q.odd};
      neg_com = 1'b0;
    end
  end

  assign dout    = dout_q;
  assign dout_oe = oe_q;
  assign sample  = smp_q;
  assign bipolar = ~cfg_q.uni;
  assign shdn_n  = shdn_q;

  // R10
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (!dout_oe && !sample));

  // R5
  smp_drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample && dout_oe));

  // R5
  null_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> !dout);

  // R11
  shdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> (!sample && !dout_oe));

endmodule

// File: tb/adc_serial_ctrl_test.sv
module adc_serial_ctrl_test;
  localparam int RES  = 12;
  localparam int SMPF = 2;
  localparam int H    = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [RES-1:0] vin = '0;
  logic cmp, dout, dout_oe, sample, neg_com, bipolar, shdn_n;
  logic [RES-1:0] dac_code;
  logic [2:0] pos_ch, neg_ch;

  assign cmp = (vin >= dac_code);
  always #2 clk = ~clk;

  adc_serial_ctrl #(.RES(RES), .SMP_FALLS(SMPF)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .cmp(cmp),
    .dout(dout), .dout_oe(dout_oe), .sample(sample), .dac_code(dac_code),
    .pos_ch(pos_ch), .neg_ch(neg_ch), .neg_com(neg_com), .bipolar(bipolar),
    .shdn_n(shdn_n));

  int n_chk = 0, n_fail = 0;
  typedef struct { logic smp; logic oe; logic d; string req; } exp_t;
  exp_t exp_q[$];
  event mid_ev;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input logic s, input logic o, input logic d, input string r);
    exp_t e;
    e.smp = s; e.oe = o; e.d = d; e.req = r;
    exp_q.push_back(e);
  endtask

  // monitor: pops one expected item per serial-clock high phase
  always @(mid_ev) begin
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(sample === e.smp, e.req, int'(sample), int'(e.smp));
      chk(dout_oe === e.oe, e.req, int'(dout_oe), int'(e.oe));
      if (e.oe) chk(dout === e.d, e.req, int'(dout), int'(e.d));
    end
  end

  task automatic tick(input logic d);
    din = d;
    repeat (H) @(negedge clk);
    sclk = 1'b1;
    repeat (H - 1) @(negedge clk);
    -> mid_ev;
    @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic run(input logic [RES-1:0] v, input logic sgl, input logic odd,
                     input logic [1:0] sel, input logic uni, input logic msbf,
                     input logic pwr, input int nlead, input int cut);
    logic [RES-1:0] code;
    logic [5:0] fld;
    code = v ^ (uni ? {RES{1'b0}} : {1'b1, {(RES-1){1'b0}}});
    fld  = {sgl, odd, sel, uni, msbf};
    vin  = v;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nlead; i++) begin push(0, 0, 0, "R2"); tick(1'b0); end
    push(0, 0, 0, "R2"); tick(1'b1);
    for (int i = 5; i >= 0; i--) begin push(0, 0, 0, "R2"); tick(fld[i]); end
    push(pwr, 0, 0, pwr ? "R4" : "R11"); tick(pwr);
    if (pwr) begin
      for (int i = 0; i < SMPF - 1; i++) begin push(1, 0, 0, "R4"); tick(1'b0); end
      push(0, 1, 0, "R5"); tick(1'b0);
      for (int j = 0; j < 2 * RES + 2; j++) begin
        if (j == cut) break;
        if (j < RES)          push(0, 1, code[RES-1-j], uni ? "R6" : "R7");
        else if (j < 2 * RES) push(0, 1, msbf ? 1'b0 : code[j-RES], msbf ? "R8" : "R9");
        else                  push(0, 1, 1'b0, msbf ? "R8" : "R9");
        tick(1'b0);
      end
    end else begin
      for (int i = 0; i < 3; i++) begin push(0, 0, 0, "R11"); tick(1'b0); end
    end
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(dout_oe === 1'b0, "R10", int'(dout_oe), 0);
    chk(sample === 1'b0, "R10", int'(sample), 0);
    chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(dout_oe === 1'b0, "R1", int'(dout_oe), 0);
    chk(sample === 1'b0, "R1", int'(sample), 0);
    chk(shdn_n === 1'b1, "R1", int'(shdn_n), 1);
    chk(bipolar === 1'b0, "R1", int'(bipolar), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 single-ended, R6/R8 unipolar MSB-first with leading zeros (R2)
    run(12'hA5C, 1, 1, 2'b10, 1, 1, 1, 3, -1);
    chk(pos_ch === 3'd5, "R3", int'(pos_ch), 5);
    chk(neg_com === 1'b1, "R3", int'(neg_com), 1);

    // R9 LSB-first replay, differential even polarity (R3)
    run(12'h3F1, 0, 0, 2'b11, 1, 0, 1, 0, -1);
    chk(pos_ch === 3'd6, "R3", int'(pos_ch), 6);
    chk(neg_ch === 3'd7, "R3", int'(neg_ch), 7);
    chk(neg_com === 1'b0, "R3", int'(neg_com), 0);

    // R7 bipolar, swapped differential polarity
    run(12'h123, 0, 1, 2'b11, 0, 1, 1, 1, -1);
    chk(pos_ch === 3'd7, "R3", int'(pos_ch), 7);
    chk(neg_ch === 3'd6, "R3", int'(neg_ch), 6);
    chk(bipolar === 1'b1, "R7", int'(bipolar), 1);

    // boundaries: full scale unipolar, zero in bipolar LSB-first (R7, R9)
    run(12'hFFF, 1, 0, 2'b00, 1, 1, 1, 0, -1);
    run(12'h000, 1, 0, 2'b00, 0, 0, 1, 2, -1);

    // R11 shutdown then recovery
    run(12'h000, 1, 0, 2'b01, 1, 1, 0, 2, -1);
    chk(shdn_n === 1'b0, "R11", int'(shdn_n), 0);
    run(12'h7FF, 1, 0, 2'b01, 1, 1, 1, 0, -1);
    chk(shdn_n === 1'b1, "R11", int'(shdn_n), 1);

    // R10 abort in the middle of readout
    run(12'h555, 1, 1, 2'b00, 1, 1, 1, 0, 5);

    // R10 abort in the middle of the control word, then a clean word
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    tick(1'b1); tick(1'b0); tick(1'b1);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(dout_oe === 1'b0, "R10", int'(dout_oe), 0);
    run(12'h0AA, 1, 0, 2'b11, 1, 1, 1, 0, -1);
    chk(pos_ch === 3'd6, "R10", int'(pos_ch), 6);
    chk(neg_com === 1'b1, "R10", int'(neg_com), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule